// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Lane Writes

This block is a single-port synchronous memory of 32-bit words. On every rising clock edge it captures the address, write data and control inputs into registers. A selected cycle then becomes a read, a write or nothing. A write commits at the following edge. It can update any mix of the four 8-bit lanes under a per-lane enable, or all lanes at once under a separate all-lanes write. A read fetches the word at the following edge into an output register.

The data bus is bidirectional at the pad. Here it appears as a write-data input, a read-data output and a drive flag, and a pad cell outside the block uses the flag to drive or float the bus. Three select inputs of mixed polarity must all be active for a cycle to count. A sleep input powers the array down. After sleep is released, the block waits a fixed number of cycles before it accepts the next access, and the stored contents are kept throughout. The depth is 2**ADDR_W words. The full-size configuration uses ADDR_W = 16, which gives 65,536 words. The default is smaller so that it elaborates quickly.

Top module: `sram_pipe_top`

## Requirements
- R1: The memory holds 2**ADDR_W independent words of LANES*LANE_W bits (defaults 4 lanes of 8 bits). Lane i is data bits [8i+7:8i].
- R2: All inputs are sampled at the rising edge. Read data for an address captured at edge E0 appears on rdata, with rdata_drive high, after edge E1. After E0 it is not yet driven. Inputs changed after E0 do not affect the result.
- R3: With wr_all_n high and byte_wr_n low, the cycle is a write in which each lane whose lane_en_n bit is low is updated and every other lane keeps its old value.
- R4: With wr_all_n low, all four lanes are written whatever byte_wr_n and lane_en_n are.
- R5: With wr_all_n and byte_wr_n both high, the cycle is a read and no lane changes, whatever lane_en_n is.
- R6: A cycle is selected only when sel_a_n is 0, sel_b is 1 and sel_c_n is 0. A cycle that is not selected writes nothing and produces no read data.
- R7: rdata_drive is low at once, without waiting for a clock, while out_en_n is high. It is also low while a write is held in the input register, even in the cycle in which read data is present.
- R8: An access captured while sleep is high is ignored, and the array contents are kept.
- R9: After sleep falls, the first three edges with sleep low ignore accesses, and the fourth edge accepts one.
- R10: A write immediately followed by a read of the same address returns the newly written lanes.
- R11: After reset, rdata_drive is low and the block is awake, so the first edge after reset accepts an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| addr | input | ADDR_W | Word address |
| wr_all_n | input | 1 | All-lanes write, active low |
| byte_wr_n | input | 1 | Lane write qualifier, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data |
| sleep | input | 1 | Power-down request, active high |
| out_en_n | input | 1 | Output enable, active low, acts without a clock |
| rdata | output | LANES*LANE_W | Read data from the output register |
| rdata_drive | output | 1 | High when the pad should drive rdata onto the bus |

## Verification
Lane writes are tried with single lanes, with two non-adjacent lanes, and with byte_wr_n low but no lane enabled. A full-word pattern is written first each time, so a wrong lane mapping or a lost lane shows up in the readback. The all-lanes write is tried with lane enables that would select nothing, which separates the priority of wr_all_n from the lane path. A read with every lane enable low separates the read decode from the lane enables. Writes are tried with each of the three selects made inactive in turn, writes during sleep and during each wake cycle go to separate addresses, and a write is followed directly by a read of the same address.

// File: rtl/sram_pkg.sv
package sram_pkg;
   typedef enum logic [1:0] {
      PWR_ON   = 2'd0,
      PWR_OFF  = 2'd1,
      PWR_WAKE = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/sram_wake_ctrl.sv
module sram_wake_ctrl #(
   parameter int WAKE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   output logic ready
);
   import sram_pkg::*;
   localparam int CNT_W = $clog2(WAKE_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

   generate
      if (WAKE_CYC < 2) begin : g_bad_wake
         $error("WAKE_CYC must be at least 2");
      end
   endgenerate

   pwr_state_t          state_q;
   logic [CNT_W-1:0]    cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWR_ON;
         cnt_q   <= '0;
      end else if (sleep) begin
         state_q <= PWR_OFF;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            PWR_OFF: begin
               state_q <= PWR_WAKE;
               cnt_q   <= CNT_W'(1);
            end
            PWR_WAKE: begin
               if (cnt_q == LAST) begin
                  state_q <= PWR_ON;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               state_q <= PWR_ON;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign ready = (state_q == PWR_ON);
endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
   parameter int LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_en_n,
   output logic             is_write,
   output logic [LANES-1:0] mask
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign mask[l] = !wr_all_n || (!byte_wr_n && !lane_en_n[l]);
      end
   endgenerate

   assign is_write = !wr_all_n || !byte_wr_n;
endmodule

// File: rtl/sram_core.sv
module sram_core #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [LANES-1:0]        mask,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DATA_W = LANES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (LANE_W < 1) begin : g_bad_lane_w
         $error("LANE_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (mask[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
         end
      end
      if (rd_en) rdata <= mem[addr];
   end
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top #(
   parameter int ADDR_W   = 10,
   parameter int LANES    = 4,
   parameter int LANE_W   = 8,
   parameter int WAKE_CYC = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr_all_n,
   input  logic                    byte_wr_n,
   input  logic [LANES-1:0]        lane_en_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    sleep,
   input  logic                    out_en_n,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_drive
);
   localparam int DATA_W = LANES * LANE_W;

   logic              awake;
   logic              dec_write;
   logic [LANES-1:0]  dec_mask;
   logic              selected;

   logic              acc_q;
   logic              wr_q;
   logic [LANES-1:0]  mask_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              out_valid_q;

   sram_wake_ctrl #(.WAKE_CYC(WAKE_CYC)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .sleep (sleep),
      .ready (awake)
   );

   sram_lane_decode #(.LANES(LANES)) u_dec (
      .wr_all_n  (wr_all_n),
      .byte_wr_n (byte_wr_n),
      .lane_en_n (lane_en_n),
      .is_write  (dec_write),
      .mask      (dec_mask)
   );

   assign selected = !sel_a_n && sel_b && !sel_c_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q       <= 1'b0;
         wr_q        <= 1'b0;
         mask_q      <= '0;
         out_valid_q <= 1'b0;
      end else begin
         acc_q       <= selected && awake && !sleep;
         wr_q        <= dec_write;
         mask_q      <= dec_mask;
         out_valid_q <= acc_q && !wr_q;
      end
   end

   always_ff @(posedge clk) begin
      addr_q  <= addr;
      wdata_q <= wdata;
   end

   sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
      .clk   (clk),
      .wr_en (acc_q && wr_q),
      .rd_en (acc_q && !wr_q),
      .mask  (mask_q),
      .addr  (addr_q),
      .wdata (wdata_q),
      .rdata (rdata)
   );

   assign rdata_drive = !out_en_n && out_valid_q && !(acc_q && wr_q);
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_a_n,
   input logic             sel_b,
   input logic             sel_c_n,
   input logic             wr_all_n,
   input logic             byte_wr_n,
   input logic             sleep,
   input logic             out_en_n,
   input logic             rdata_drive,
   input logic             awake,
   input logic             acc_q,
   input logic             out_valid_q,
   input logic [LANES-1:0] mask_q
);
   logic sel_now;
   logic take_now;
   assign sel_now  = !sel_a_n && sel_b && !sel_c_n;
   assign take_now = sel_now && awake && !sleep;

   AST_OE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rdata_drive);                                   // R7
   AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_now && (!wr_all_n || !byte_wr_n)) |=> !rdata_drive);    // R7
   AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (take_now && !wr_all_n) |=> (mask_q == '1));                  // R4
   AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_now && wr_all_n && byte_wr_n) |=> ##1 out_valid_q);     // R2
   AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_now |=> !acc_q);                                         // R6
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!awake && !acc_q));                                // R8
   AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awake) |-> (!$past(sleep) && !$past(sleep, 2)));        // R9
endmodule

bind sram_pipe_top sram_pipe_chk #(.LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_a_n     (sel_a_n),
   .sel_b       (sel_b),
   .sel_c_n     (sel_c_n),
   .wr_all_n    (wr_all_n),
   .byte_wr_n   (byte_wr_n),
   .sleep       (sleep),
   .out_en_n    (out_en_n),
   .rdata_drive (rdata_drive),
   .awake       (awake),
   .acc_q       (acc_q),
   .out_valid_q (out_valid_q),
   .mask_q      (mask_q)
);

// File: tb/tb_sram_pipe_top.sv
module tb_sram_pipe_top;
   localparam int AW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_a_n, sel_b, sel_c_n;
   logic [AW-1:0] addr;
   logic        wr_all_n, byte_wr_n;
   logic [3:0]  lane_en_n;
   logic [31:0] wdata;
   logic        sleep, out_en_n;
   logic [31:0] rdata;
   logic        rdata_drive;

   int checks = 0;
   int errors = 0;

   sram_pipe_top #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .addr(addr), .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_en_n(lane_en_n),
      .wdata(wdata), .sleep(sleep), .out_en_n(out_en_n), .rdata(rdata),
      .rdata_drive(rdata_drive)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
      wr_all_n = 1'b1; byte_wr_n = 1'b1; lane_en_n = 4'hF;
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [31:0] d, input logic gw,
                      input logic bw, input logic [3:0] ln);
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      addr = a; wdata = d; wr_all_n = gw; byte_wr_n = bw; lane_en_n = ln;
   endtask

   // each task starts and ends at a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic gw,
                     input logic bw, input logic [3:0] ln);
      put(a, d, gw, bw, ln);
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
      put(a, 32'h0, 1'b1, 1'b1, 4'hF);
      @(negedge clk);
      idle();
      check(rdata_drive == 1'b0, "R2 early", {31'b0, rdata_drive}, 32'h0);
      @(negedge clk);
      check(rdata_drive == 1'b1, req, {31'b0, rdata_drive}, 32'h1);
      check(rdata == exp, req, rdata, exp);
   endtask

   task automatic t_reset();
      check(rdata_drive == 1'b0, "R11", {31'b0, rdata_drive}, 32'h0);
      wr(10'h001, 32'h1234_5678, 1'b0, 1'b1, 4'hF);   // first edge after reset
      rd(10'h001, 32'h1234_5678, "R11");
   endtask

   task automatic t_lanes();
      wr(10'h010, 32'hAAAA_AAAA, 1'b0, 1'b1, 4'hF);
      wr(10'h010, 32'h1122_3344, 1'b1, 1'b0, 4'b1110);
      rd(10'h010, 32'hAAAA_AA44, "R3 lane0");
      wr(10'h010, 32'h5566_7788, 1'b1, 1'b0, 4'b0101);
      rd(10'h010, 32'h55AA_77_44, "R3 lanes1,3");
      wr(10'h010, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'hF);    // write cycle, no lanes
      rd(10'h010, 32'h55AA_7744, "R3 no lane");
      wr(10'h011, 32'h0BAD_F00D, 1'b0, 1'b1, 4'hF);
      wr(10'h012, 32'h0000_0000, 1'b0, 1'b1, 4'hF);
      rd(10'h011, 32'h0BAD_F00D, "R1 distinct words");
   endtask

   task automatic t_global();
      wr(10'h020, 32'h0000_0000, 1'b0, 1'b1, 4'hF);
      wr(10'h020, 32'hCAFE_BEEF, 1'b0, 1'b0, 4'hF);
      rd(10'h020, 32'hCAFE_BEEF, "R4");
   endtask

   task automatic t_read_decode();
      wr(10'h030, 32'h1357_9BDF, 1'b0, 1'b1, 4'hF);
      put(10'h030, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);  // read despite lanes low
      @(negedge clk);
      idle();
      @(negedge clk);
      check(rdata == 32'h1357_9BDF, "R5", rdata, 32'h1357_9BDF);
      rd(10'h030, 32'h1357_9BDF, "R5 unchanged");
   endtask

   task automatic t_select();
      wr(10'h040, 32'h4444_4444, 1'b0, 1'b1, 4'hF);
      put(10'h040, 32'h0000_0001, 1'b0, 1'b1, 4'hF); sel_a_n = 1'b1; @(negedge clk);
      put(10'h040, 32'h0000_0002, 1'b0, 1'b1, 4'hF); sel_b = 1'b0;   @(negedge clk);
      put(10'h040, 32'h0000_0003, 1'b0, 1'b1, 4'hF); sel_c_n = 1'b1; @(negedge clk);
      put(10'h040, 32'h0, 1'b1, 1'b1, 4'hF); sel_b = 1'b0;           @(negedge clk);
      idle();
      @(negedge clk);
      check(rdata_drive == 1'b0, "R6 deselected read", {31'b0, rdata_drive}, 32'h0);
      rd(10'h040, 32'h4444_4444, "R6");
   endtask

   task automatic t_oe();
      wr(10'h050, 32'h5A5A_0FF0, 1'b0, 1'b1, 4'hF);
      put(10'h050, 32'h0, 1'b1, 1'b1, 4'hF);
      @(negedge clk);
      idle();
      @(negedge clk);
      out_en_n = 1'b1;
      #1;
      check(rdata_drive == 1'b0, "R7 oe off", {31'b0, rdata_drive}, 32'h0);
      out_en_n = 1'b0;
      #1;
      check(rdata_drive == 1'b1, "R7 oe on", {31'b0, rdata_drive}, 32'h1);
      @(negedge clk);
      put(10'h050, 32'h0, 1'b1, 1'b1, 4'hF);         // read, then write behind it
      @(negedge clk);
      put(10'h051, 32'h7777_7777, 1'b0, 1'b1, 4'hF);
      @(negedge clk);
      idle();
      check(rdata_drive == 1'b0, "R7 write held", {31'b0, rdata_drive}, 32'h0);
      rd(10'h051, 32'h7777_7777, "R7 write landed");
   endtask

   task automatic t_b2b();
      wr(10'h060, 32'h0101_0101, 1'b0, 1'b1, 4'hF);
      wr(10'h060, 32'h0000_EE00, 1'b1, 1'b0, 4'b1101);
      rd(10'h060, 32'h0101_EE01, "R10");
   endtask

   task automatic t_sleep();
      wr(10'h070, 32'h7070_7070, 1'b0, 1'b1, 4'hF);
      wr(10'h071, 32'h7171_7171, 1'b0, 1'b1, 4'hF);
      wr(10'h072, 32'h7272_7272, 1'b0, 1'b1, 4'hF);
      sleep = 1'b1;
      put(10'h070, 32'hDEAD_0000, 1'b0, 1'b1, 4'hF);
      @(negedge clk);
      put(10'h070, 32'h0, 1'b1, 1'b1, 4'hF);          // read while asleep
      @(negedge clk);
      @(negedge clk);
      check(rdata_drive == 1'b0, "R8 no read", {31'b0, rdata_drive}, 32'h0);
      sleep = 1'b0;
      for (int i = 0; i < 3; i++) begin
         put(10'h071, 32'hBEEF_0000 + i, 1'b0, 1'b1, 4'hF);
         @(negedge clk);
      end
      wr(10'h072, 32'h0F0F_0F0F, 1'b0, 1'b1, 4'hF);
      rd(10'h070, 32'h7070_7070, "R8");
      rd(10'h071, 32'h7171_7171, "R9 wake ignored");
      rd(10'h072, 32'h0F0F_0F0F, "R9 fourth edge");
   endtask

   initial begin
      idle();
      addr = '0; wdata = '0; sleep = 1'b0; out_en_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lanes();
      t_global();
      t_read_decode();
      t_select();
      t_oe();
      t_b2b();
      t_sleep();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule